// File: doc/BRIEF.md
# Accumulator CPU with Micro-Sequenced Register Transfers

This block is a small multicycle processor built around one 16-bit accumulator. Every instruction word has a 4-bit operation code in its upper nibble and a 12-bit word address in its lower twelve bits. A control state machine runs each instruction as a short chain of register transfers through an address register and a data buffer register. The chain covers fetch, decode, an optional operand read, and the execute step. Data is in two's complement.

Program and data share one external synchronous single-port RAM of 4096 words of 16 bits. The CPU requests a read, waits one cycle, and takes the word on the next cycle. An 8-bit input port is polled until its valid flag is high. An 8-bit output register is loaded together with a one-clock valid strobe. Once a halt operation is decoded the CPU stops for good and raises `halted`.

Top module: `acc_cpu`

## Requirements
- R1: After reset the CPU runs from address 0. Each instruction is fetched from the word that PC addresses, and PC then advances by one. Bits 15..12 hold the opcode and bits 11..0 hold the address field.
- R2: Opcode 1 (load) copies the addressed word into AC. Opcode 2 (store) writes AC into the addressed word.
- R3: Opcode 3 adds the addressed word to AC and opcode 4 subtracts it, both modulo 2^16.
- R4: Opcode A sets AC to zero.
- R5: Opcode 8 skips the next instruction according to bits 11..10: 00 skips when AC is negative, 01 when AC is zero, 10 when AC is positive, and 11 never skips.
- R6: Opcode 9 continues execution at the address field.
- R7: Opcode 0 writes the return address (the address after the jump) into the target word, then continues execution at target plus one.
- R8: Opcode B adds the word whose address is held in the target word. Opcode C continues execution at the address held in the target word.
- R9: Opcode 5 stalls until `in_valid` is high, then loads the sign-extended `in_data` into AC and pulses `in_ack` for exactly one cycle. `in_ack` is never high while `in_valid` is low.
- R10: Opcode 6 puts the low 8 bits of AC on `out_data` and pulses `out_valid` for one cycle. `out_data` changes only together with that pulse and is 0 after reset.
- R11: Opcode 7, and opcodes D, E and F, stop the CPU. `halted` then stays high until reset. While halted the CPU makes no memory request and no output, and the instructions after the halt have no effect.
- R12: A read request is always followed by a cycle with no request, and the read data is used in that cycle. No request is made during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| in_data | input | 8 | Input port value |
| in_valid | input | 1 | Input value present |
| in_ack | output | 1 | Input value taken |
| out_data | output | 8 | Output register |
| out_valid | output | 1 | One-cycle strobe on a new output value |
| halted | output | 1 | Execution has stopped |

## Verification
The bench builds the CPU with its default parameters: 16-bit data, 12-bit addresses and 8-bit ports. With these widths, additions and subtractions can wrap across 0x7FFF/0x8000 and 0xFFFF/0x0000. A negative input byte also shows its sign extension into the full word. Placing programs, pointers and the return-address slot at separate addresses exercises the indirect paths and the subroutine jump. Every skip code is tried on both sides of its condition.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  localparam logic [3:0] OPC_JNS   = 4'h0;
  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_ADD   = 4'h3;
  localparam logic [3:0] OPC_SUB   = 4'h4;
  localparam logic [3:0] OPC_INPUT = 4'h5;
  localparam logic [3:0] OPC_OUT   = 4'h6;
  localparam logic [3:0] OPC_SKIP  = 4'h8;
  localparam logic [3:0] OPC_JUMP  = 4'h9;
  localparam logic [3:0] OPC_CLEAR = 4'hA;
  localparam logic [3:0] OPC_ADDI  = 4'hB;
  localparam logic [3:0] OPC_JUMPI = 4'hC;

  typedef enum logic [3:0] {
    ST_F0, ST_F1, ST_F2, ST_DEC, ST_RD, ST_RDW, ST_EXE,
    ST_WR0, ST_WR1, ST_JNS, ST_INW, ST_HALT
  } state_e;

  typedef enum logic [1:0] {MAR_PC, MAR_IR, MAR_MBR} mar_src_e;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_IR, PC_MBR, PC_MAR1} pc_op_e;
  typedef enum logic [1:0] {MBR_MEM, MBR_AC, MBR_PC} mbr_src_e;
  typedef enum logic [2:0] {AC_HOLD, AC_MBR, AC_ADD, AC_SUB, AC_ZERO, AC_IN} ac_op_e;

  typedef struct packed {
    logic     mar_en;
    mar_src_e mar_src;
    logic     ir_en;
    pc_op_e   pc_op;
    logic     mbr_en;
    mbr_src_e mbr_src;
    ac_op_e   ac_op;
    logic     out_en;
    logic     mem_req;
    logic     mem_we;
    logic     in_ack;
  } ctl_t;
endpackage

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  ac_op_e            op,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] mbr,
  input  logic [IO_W-1:0]   in_data,
  input  logic [1:0]        cond,
  output logic [DATA_W-1:0] ac_nxt,
  output logic              skip_take
);
  localparam int EXT_W = DATA_W - IO_W;

  logic ac_neg, ac_zero;
  assign ac_neg  = ac[DATA_W-1];
  assign ac_zero = (ac == '0);

  always_comb begin
    unique case (cond)
      2'b00:   skip_take = ac_neg;
      2'b01:   skip_take = ac_zero;
      2'b10:   skip_take = !ac_neg && !ac_zero;
      default: skip_take = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      AC_MBR:  ac_nxt = mbr;
      AC_ADD:  ac_nxt = ac + mbr;
      AC_SUB:  ac_nxt = ac - mbr;
      AC_ZERO: ac_nxt = '0;
      AC_IN:   ac_nxt = {{EXT_W{in_data[IO_W-1]}}, in_data};
      default: ac_nxt = ac;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
`timescale 1ns/1ps
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  input  logic       skip_take,
  input  logic       in_valid,
  output ctl_t       ctl,
  output logic       halted
);
  state_e state_q, state_d;
  logic   ind_q, ind_d;

  always_comb begin
    ctl     = '0;
    state_d = state_q;
    ind_d   = ind_q;
    case (state_q)
      ST_F0: begin
        ctl.mar_en  = 1'b1;
        ctl.mar_src = MAR_PC;
        state_d     = ST_F1;
      end
      ST_F1: begin
        ctl.mem_req = 1'b1;
        state_d     = ST_F2;
      end
      ST_F2: begin
        ctl.ir_en = 1'b1;
        ctl.pc_op = PC_INC;
        state_d   = ST_DEC;
      end
      ST_DEC: begin
        ctl.mar_en  = 1'b1;
        ctl.mar_src = MAR_IR;
        ind_d       = 1'b0;
        state_d     = ST_F0;
        case (opcode)
          OPC_LOAD, OPC_ADD, OPC_SUB, OPC_ADDI, OPC_JUMPI: state_d = ST_RD;
          OPC_STORE, OPC_JNS: state_d = ST_WR0;
          OPC_INPUT: state_d = ST_INW;
          OPC_OUT:   ctl.out_en = 1'b1;
          OPC_SKIP:  if (skip_take) ctl.pc_op = PC_INC;
          OPC_JUMP:  ctl.pc_op = PC_IR;
          OPC_CLEAR: ctl.ac_op = AC_ZERO;
          default:   state_d = ST_HALT;
        endcase
      end
      ST_RD: begin
        ctl.mem_req = 1'b1;
        state_d     = ST_RDW;
      end
      ST_RDW: begin
        ctl.mbr_en  = 1'b1;
        ctl.mbr_src = MBR_MEM;
        state_d     = ST_EXE;
      end
      ST_EXE: begin
        state_d = ST_F0;
        case (opcode)
          OPC_LOAD: ctl.ac_op = AC_MBR;
          OPC_ADD:  ctl.ac_op = AC_ADD;
          OPC_SUB:  ctl.ac_op = AC_SUB;
          OPC_ADDI: begin
            if (!ind_q) begin
              ctl.mar_en  = 1'b1;
              ctl.mar_src = MAR_MBR;
              ind_d       = 1'b1;
              state_d     = ST_RD;
            end else begin
              ctl.ac_op = AC_ADD;
            end
          end
          OPC_JUMPI: ctl.pc_op = PC_MBR;
          default: ;
        endcase
      end
      ST_WR0: begin
        ctl.mbr_en  = 1'b1;
        ctl.mbr_src = (opcode == OPC_JNS) ? MBR_PC : MBR_AC;
        state_d     = ST_WR1;
      end
      ST_WR1: begin
        ctl.mem_req = 1'b1;
        ctl.mem_we  = 1'b1;
        state_d     = (opcode == OPC_JNS) ? ST_JNS : ST_F0;
      end
      ST_JNS: begin
        ctl.pc_op = PC_MAR1;
        state_d   = ST_F0;
      end
      ST_INW: begin
        if (in_valid) begin
          ctl.ac_op  = AC_IN;
          ctl.in_ack = 1'b1;
          state_d    = ST_F0;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_F0;
      ind_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ind_q   <= ind_d;
    end
  end

  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_valid,
  output logic              in_ack,
  output logic [IO_W-1:0]   out_data,
  output logic              out_valid,
  output logic              halted
);
  localparam int OPC_LSB = DATA_W - 4;
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  ctl_t              ctl;
  logic              skip_take;
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] ir_q, mbr_q, mbr_d, ac_q, ac_nxt;
  logic [IO_W-1:0]   out_q;
  logic              out_v_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .opcode   (ir_q[DATA_W-1:OPC_LSB]),
    .skip_take(skip_take),
    .in_valid (in_valid),
    .ctl      (ctl),
    .halted   (halted)
  );

  acc_alu #(.DATA_W(DATA_W), .IO_W(IO_W)) u_alu (
    .op       (ctl.ac_op),
    .ac       (ac_q),
    .mbr      (mbr_q),
    .in_data  (in_data),
    .cond     (ir_q[ADDR_W-1:ADDR_W-2]),
    .ac_nxt   (ac_nxt),
    .skip_take(skip_take)
  );

  always_comb begin
    case (ctl.mar_src)
      MAR_IR:  mar_d = ir_q[ADDR_W-1:0];
      MAR_MBR: mar_d = mbr_q[ADDR_W-1:0];
      default: mar_d = pc_q;
    endcase
    case (ctl.pc_op)
      PC_INC:  pc_d = pc_q + ADDR_W'(1);
      PC_IR:   pc_d = ir_q[ADDR_W-1:0];
      PC_MBR:  pc_d = mbr_q[ADDR_W-1:0];
      PC_MAR1: pc_d = mar_q + ADDR_W'(1);
      default: pc_d = pc_q;
    endcase
    case (ctl.mbr_src)
      MBR_AC:  mbr_d = ac_q;
      MBR_PC:  mbr_d = {{PAD_W{1'b0}}, pc_q};
      default: mbr_d = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pc_q    <= '0;
      mar_q   <= '0;
      ir_q    <= '0;
      mbr_q   <= '0;
      ac_q    <= '0;
      out_q   <= '0;
      out_v_q <= 1'b0;
    end else begin
      if (ctl.mar_en)            mar_q <= mar_d;
      if (ctl.ir_en)             ir_q  <= mem_rdata;
      if (ctl.pc_op != PC_HOLD)  pc_q  <= pc_d;
      if (ctl.mbr_en)            mbr_q <= mbr_d;
      if (ctl.ac_op != AC_HOLD)  ac_q  <= ac_nxt;
      if (ctl.out_en)            out_q <= ac_q[IO_W-1:0];
      out_v_q <= ctl.out_en;
    end
  end

  assign mem_req   = ctl.mem_req;
  assign mem_we    = ctl.mem_we;
  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign in_ack    = ctl.in_ack;
  assign out_data  = out_q;
  assign out_valid = out_v_q;
endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk #(
  parameter int IO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            in_valid,
  input logic            in_ack,
  input logic [IO_W-1:0] out_data,
  input logic            out_valid,
  input logic            halted
);
  assert_rd_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !out_valid && !in_ack));

  assert_out_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

  assert_ack_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> in_valid);

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);
endmodule

bind acc_cpu acc_cpu_chk #(.IO_W(IO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .in_valid (in_valid),
  .in_ack   (in_ack),
  .out_data (out_data),
  .out_valid(out_valid),
  .halted   (halted)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_we, in_ack, out_valid, halted, in_valid;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0]  in_data, out_data;

  logic [15:0] mem [0:4095];
  logic        ld_en;
  logic [11:0] ld_a;
  logic [15:0] ld_d;

  int checks = 0, fails = 0;
  int out_cnt = 0, ack_cnt = 0, proto_bad = 0, halt_req = 0;
  logic [7:0] last_out;
  logic prev_rd;

  always #10 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
    .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  // synchronous single-port RAM, one-cycle read latency
  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) prev_rd <= 1'b0;
    else begin
      if (prev_rd && mem_req) proto_bad++;
      if (halted && mem_req) halt_req++;
      if (out_valid) begin out_cnt++; last_out <= out_data; end
      if (in_ack) ack_cnt++;
      prev_rd <= mem_req && !mem_we;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    out_cnt = 0; ack_cnt = 0;
  endtask

  task automatic release_and_wait(input string req);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check(req, {15'd0, halted}, 16'd1);
  endtask

  // {opcode, cond, a, b, expected}
  localparam int NV = 16;
  localparam logic [53:0] VEC [NV] = '{
    {4'h3, 2'd0, 16'h0005, 16'h0007, 16'h000C},
    {4'h3, 2'd0, 16'h7FFF, 16'h0001, 16'h8000},
    {4'h3, 2'd0, 16'hFFFF, 16'h0001, 16'h0000},
    {4'h4, 2'd0, 16'h0003, 16'h0005, 16'hFFFE},
    {4'h4, 2'd0, 16'h8000, 16'h0001, 16'h7FFF},
    {4'hB, 2'd0, 16'h000A, 16'h0020, 16'h002A},
    {4'h1, 2'd0, 16'h1111, 16'h1234, 16'h1234},
    {4'hA, 2'd0, 16'h5555, 16'h0000, 16'h0000},
    {4'h8, 2'd0, 16'hFFFF, 16'h0009, 16'hFFFF},
    {4'h8, 2'd0, 16'h0000, 16'h0009, 16'h0009},
    {4'h8, 2'd1, 16'h0000, 16'h0009, 16'h0000},
    {4'h8, 2'd1, 16'h0003, 16'h0009, 16'h0009},
    {4'h8, 2'd2, 16'h0003, 16'h0009, 16'h0003},
    {4'h8, 2'd2, 16'h8000, 16'h0009, 16'h0009},
    {4'h8, 2'd3, 16'h0000, 16'h0009, 16'h0009},
    {4'h8, 2'd3, 16'h7FFF, 16'h0009, 16'h0009}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h3, 4'h4: return "R3 add/sub";
      4'hB:       return "R8 indirect add";
      4'h1:       return "R2 load/store";
      4'hA:       return "R4 clear";
      default:    return "R5 skip";
    endcase
  endfunction

  task automatic io_test(input logic [7:0] v, input logic [15:0] exp);
    hold_reset();
    in_valid = 1'b0;
    poke(12'h000, 16'h5000);
    poke(12'h001, 16'h6000);
    poke(12'h002, 16'h2102);
    poke(12'h003, 16'h7000);
    poke(12'h102, 16'hDEAD);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 stalls without input", {14'd0, halted, out_valid}, 16'd0);
    check("R9 no ack without input", ack_cnt[15:0], 16'd0);
    in_data = v; in_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (in_ack) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check("R9 sign-extended input", mem[12'h102], exp);
    check("R9 single ack", ack_cnt[15:0], 16'd1);
    check("R10 single output strobe", out_cnt[15:0], 16'd1);
    check("R10 output value", {8'd0, last_out}, {8'd0, v});
    check("R10 output register", {8'd0, out_data}, {8'd0, v});
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_a = '0; ld_d = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // reset state
    check("R11 halted low in reset", {15'd0, halted}, 16'd0);
    check("R10 output clear in reset", {7'd0, out_valid, out_data}, 16'd0);
    check("R12 no request in reset", {15'd0, mem_req}, 16'd0);

    // table of single-operation programs
    for (int k = 0; k < NV; k++) begin
      logic [3:0]  op;
      logic [1:0]  cd;
      logic [15:0] a, b, e;
      {op, cd, a, b, e} = VEC[k];
      hold_reset();
      poke(12'h100, a);
      poke(12'h101, b);
      poke(12'h104, 16'h0101);
      poke(12'h102, 16'hDEAD);
      poke(12'h000, 16'h1100);
      if (op == 4'h8) begin
        poke(12'h001, {4'h8, cd, 10'd0});
        poke(12'h002, 16'h1101);
        poke(12'h003, 16'h2102);
        poke(12'h004, 16'h7000);
      end else begin
        case (op)
          4'hB:    poke(12'h001, 16'hB104);
          4'hA:    poke(12'h001, 16'hA000);
          default: poke(12'h001, {op, 12'h101});
        endcase
        poke(12'h002, 16'h2102);
        poke(12'h003, 16'h7000);
      end
      release_and_wait("R1 program reaches halt");
      check(tag_of(op), mem[12'h102], e);
    end

    // R6 direct jump
    hold_reset();
    poke(12'h000, 16'h9005);
    poke(12'h001, 16'h7000);
    poke(12'h005, 16'h1100);
    poke(12'h006, 16'h2102);
    poke(12'h007, 16'h7000);
    poke(12'h100, 16'h2468);
    poke(12'h102, 16'hDEAD);
    release_and_wait("R6 jump program halts");
    check("R6 jump target executed", mem[12'h102], 16'h2468);

    // R7 subroutine jump, R8 indirect return
    hold_reset();
    poke(12'h000, 16'h0020);
    poke(12'h001, 16'h2102);
    poke(12'h002, 16'h7000);
    poke(12'h020, 16'h0000);
    poke(12'h021, 16'h1100);
    poke(12'h022, 16'hC020);
    poke(12'h100, 16'h4321);
    poke(12'h102, 16'hDEAD);
    release_and_wait("R7 subroutine program halts");
    check("R7 return address stored", mem[12'h020], 16'h0001);
    check("R8 indirect jump returns", mem[12'h102], 16'h4321);

    // R9 / R10 input and output
    io_test(8'h9C, 16'hFF9C);
    io_test(8'h45, 16'h0045);

    // R11 opcode E halts, following store has no effect
    hold_reset();
    poke(12'h000, 16'hE000);
    poke(12'h001, 16'h2102);
    poke(12'h102, 16'hDEAD);
    halt_req = 0;
    release_and_wait("R11 alias opcode halts");
    repeat (10) @(negedge clk);
    check("R11 halted stays high", {15'd0, halted}, 16'd1);
    check("R11 store after halt ignored", mem[12'h102], 16'hDEAD);
    check("R11 no request while halted", halt_req[15:0], 16'd0);
    check("R12 read followed by idle cycle", proto_bad[15:0], 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule